// File: doc/BRIEF.md
# I2C Target Address Front End with Four-State Strap Decoding

This block is the receive front end of an I2C/SMBus target. It watches the two bus lines, recognises START and STOP, shifts in the first byte of each transfer (seven address bits, most significant first, then the read/write bit), and decides whether that byte names this device. If it does, the block pulls SDA low for the acknowledge clock. The block never drives SCL. Its only drive onto the bus is the SDA pull-down enable.

The device address is not fixed. Two strap pins select one of sixteen addresses. Each strap can be wired to ground, to the supply, to the SDA line or to the SCL line. During the address phase of every transfer, the block compares each strap against the live bus lines and decides which of the four connections it has. Because this happens on every transfer, rewiring a strap takes effect at the next START. The resolved address is the fixed prefix `100` followed by two bits per strap. The higher-indexed strap fills the upper pair of bits.

All four inputs go through the same multi-stage synchroniser, so a strap wired to SDA or SCL stays aligned with the line it follows. The system clock must run at least eight times faster than SCL.

Top module: `i2c_strap_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high (both as seen after synchronisation). START enters address reception. STOP returns the block to idle and clears `addr_match_o` and `sda_pull_o`.
- R2: The first byte after START is taken MSB first on SCL rising edges. At the eighth rising edge `rw_o` takes the eighth bit (1 = read).
- R3: At the eighth rising edge `addr_o` takes the resolved address `{3'b100, code(straps_i[1]), code(straps_i[0])}`, with code GND=00, VS=01, SDA=10, SCL=11. This holds provided the address byte begins with bits 1 then 0.
- R4: `addr_match_o` rises at the eighth rising edge when the received seven address bits equal the resolved address. It stays high until the next START or STOP.
- R5: On a match, `sda_pull_o` goes high after the SCL fall that ends bit eight and goes low after the SCL fall that ends the ninth clock. It is low at all other times.
- R6: On a mismatch, `sda_pull_o` stays low through any further bytes until the next START or STOP.
- R7: Strap classification is redone for every transfer. A changed strap wiring produces the new address at the next transfer.
- R8: A repeated START, sent without a STOP, restarts address reception and classification. It can turn a mismatched transfer into a matched one.
- R9: If a strap fits none of the four connections, `addr_o` reports 0 and no acknowledge is given.
- R10: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (including this block's own pull-down) |
| straps_i | input | N_STRAP | Strap pin levels; index 1 gives address bits [3:2], index 0 gives bits [1:0] |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| addr_match_o | output | 1 | Received address equals the resolved address |
| rw_o | output | 1 | Direction bit of the last address byte |
| addr_o | output | ADDR_W | Address resolved from the straps at the last address byte |

## Verification
The hardest case to reach is telling a strap wired to SDA apart from one wired to SCL or to a fixed level. The only evidence comes from how the master moves SDA relative to SCL during the address byte. The bench therefore wires each strap as a live function of the bus lines it models, including the block's own pull-down. It sets SDA a quarter period into each SCL low phase, so that a high bit is held while SCL is low. It then walks all sixteen strap pairings and one strap that follows an inverted SDA. A reference model predicts every output cycle by cycle from the wiring that was chosen, not from the classifier's flags.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

   typedef enum logic [1:0] {
      STRAP_GND = 2'b00,
      STRAP_VS  = 2'b01,
      STRAP_SDA = 2'b10,
      STRAP_SCL = 2'b11
   } strap_code_e;

   typedef enum logic [2:0] {
      TS_IDLE,
      TS_ADDR,
      TS_ACK_WAIT,
      TS_ACK_DRIVE,
      TS_HOLD,
      TS_SKIP
   } tgt_state_e;

endpackage

// File: rtl/i2c_sync_bank.sv
module i2c_sync_bank #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_sync_bank: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= {STAGES{RST_VAL}};
      else        stage_q <= {stage_q[STAGES-2:0], d_i};
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   // data-line edges only count while the clock line stayed high
   assign start_o = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
   assign rise_o  = scl_i & ~scl_q;
   assign fall_o  = ~scl_i & scl_q;

endmodule

// File: rtl/strap_classifier.sv
module strap_classifier
   import i2c_strap_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear_i,
   input  logic        sample_i,
   input  logic        scl_i,
   input  logic        sda_i,
   input  logic        strap_i,
   output strap_code_e code_o,
   output logic        valid_o
);

   logic seen_hi, seen_lo, diff_scl, diff_sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_hi  <= 1'b0;
         seen_lo  <= 1'b0;
         diff_scl <= 1'b0;
         diff_sda <= 1'b0;
      end else if (clear_i) begin
         seen_hi  <= 1'b0;
         seen_lo  <= 1'b0;
         diff_scl <= 1'b0;
         diff_sda <= 1'b0;
      end else if (sample_i) begin
         seen_hi  <= seen_hi | strap_i;
         seen_lo  <= seen_lo | ~strap_i;
         diff_scl <= diff_scl | (strap_i ^ scl_i);
         // data relation only judged while SCL is high, so the data
         // line moving during the low phase cannot spoil it
         diff_sda <= diff_sda | (scl_i & (strap_i ^ sda_i));
      end
   end

   always_comb begin
      valid_o = 1'b1;
      if (!seen_hi)       code_o = STRAP_GND;
      else if (!seen_lo)  code_o = STRAP_VS;
      else if (!diff_scl) code_o = STRAP_SCL;
      else if (!diff_sda) code_o = STRAP_SDA;
      else begin
         code_o  = STRAP_GND;
         valid_o = 1'b0;
      end
   end

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
   import i2c_strap_pkg::*;
#(
   parameter int                  N_STRAP     = 2,
   parameter int                  PREFIX_W    = 3,
   parameter logic [PREFIX_W-1:0] PREFIX      = 3'b100,
   parameter int                  ADDR_W      = 7,
   parameter int                  SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [N_STRAP-1:0] straps_i,
   output logic               sda_pull_o,
   output logic               addr_match_o,
   output logic               rw_o,
   output logic [ADDR_W-1:0]  addr_o
);

   localparam int CODE_W = 2;
   localparam int SYNC_W = 2 + N_STRAP;
   localparam int CNT_W  = $clog2(ADDR_W + 2);

   generate
      if (ADDR_W != PREFIX_W + CODE_W * N_STRAP) begin : g_bad_width
         $error("i2c_strap_target: ADDR_W must equal PREFIX_W + 2*N_STRAP");
      end
      if (N_STRAP < 1) begin : g_bad_straps
         $error("i2c_strap_target: N_STRAP must be at least 1");
      end
   endgenerate

   // synchronised view: one bank so straps stay aligned with the lines
   logic [SYNC_W-1:0]  sync_q;
   logic               scl_s, sda_s;
   logic [N_STRAP-1:0] strap_s;

   i2c_sync_bank #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL({SYNC_W{1'b1}})
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({straps_i, sda_i, scl_i}),
      .q_o  (sync_q)
   );

   assign scl_s   = sync_q[0];
   assign sda_s   = sync_q[1];
   assign strap_s = sync_q[SYNC_W-1:2];

   logic start_ev, stop_ev, rise_ev, fall_ev;

   i2c_bus_events u_events (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_s),
      .sda_i  (sda_s),
      .start_o(start_ev),
      .stop_o (stop_ev),
      .rise_o (rise_ev),
      .fall_o (fall_ev)
   );

   tgt_state_e state;

   logic [N_STRAP*CODE_W-1:0] code_bus;
   logic [N_STRAP-1:0]        valid_bus;

   generate
      for (genvar i = 0; i < N_STRAP; i++) begin : g_strap
         strap_code_e code_i;
         strap_classifier u_cls (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (start_ev),
            .sample_i(state == TS_ADDR),
            .scl_i   (scl_s),
            .sda_i   (sda_s),
            .strap_i (strap_s[i]),
            .code_o  (code_i),
            .valid_o (valid_bus[i])
         );
         assign code_bus[i*CODE_W +: CODE_W] = code_i;
      end
   endgenerate

   logic [ADDR_W-1:0] resolved;
   logic              all_valid;

   assign resolved  = {PREFIX, code_bus};
   assign all_valid = &valid_bus;

   logic [ADDR_W-1:0] shreg;
   logic [CNT_W-1:0]  bit_cnt;
   logic              last_bit, hit;

   // shreg already holds the seven address bits when the 8th rise arrives
   assign last_bit = (bit_cnt == CNT_W'(ADDR_W));
   assign hit      = all_valid && (shreg == resolved);

   logic              pull_q, match_q, rw_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TS_IDLE;
         shreg   <= '0;
         bit_cnt <= '0;
         pull_q  <= 1'b0;
         match_q <= 1'b0;
         rw_q    <= 1'b0;
         addr_q  <= '0;
      end else if (start_ev) begin
         state   <= TS_ADDR;
         bit_cnt <= '0;
         pull_q  <= 1'b0;
         match_q <= 1'b0;
      end else if (stop_ev) begin
         state   <= TS_IDLE;
         pull_q  <= 1'b0;
         match_q <= 1'b0;
      end else begin
         unique case (state)
            TS_ADDR: begin
               if (rise_ev) begin
                  shreg   <= {shreg[ADDR_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
                  if (last_bit) begin
                     rw_q   <= sda_s;
                     addr_q <= all_valid ? resolved : '0;
                     if (hit) begin
                        match_q <= 1'b1;
                        state   <= TS_ACK_WAIT;
                     end else begin
                        state   <= TS_SKIP;
                     end
                  end
               end
            end
            TS_ACK_WAIT: begin
               if (fall_ev) begin
                  pull_q <= 1'b1;
                  state  <= TS_ACK_DRIVE;
               end
            end
            TS_ACK_DRIVE: begin
               if (fall_ev) begin
                  pull_q <= 1'b0;
                  state  <= TS_HOLD;
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_pull_o   = pull_q;
   assign addr_match_o = match_q;
   assign rw_o         = rw_q;
   assign addr_o       = addr_q;

endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start_ev,
   input logic              stop_ev,
   input logic              sda_pull_o,
   input logic              addr_match_o,
   input logic [ADDR_W-1:0] addr_o
);

   // R5: acknowledge is only ever given for a matched address
   p_pull_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_o |-> addr_match_o);

   // R5: the pull-down starts while SCL is low
   p_pull_starts_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_s);

   // R4: a match persists until a START or STOP
   p_match_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match_o && !start_ev && !stop_ev) |=> addr_match_o);

   // R1: STOP clears match and pull-down
   p_stop_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (!addr_match_o && !sda_pull_o));

   // R8: a (repeated) START clears match and pull-down
   p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (!addr_match_o && !sda_pull_o));

   // R9: an address is never reported with a wrong prefix
   p_addr_prefix_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_o != '0) |-> (addr_o[ADDR_W-1 -: 3] == 3'b100));

endmodule

bind i2c_strap_target i2c_strap_target_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_s       (scl_s),
   .start_ev    (start_ev),
   .stop_ev     (stop_ev),
   .sda_pull_o  (sda_pull_o),
   .addr_match_o(addr_match_o),
   .addr_o      (addr_o)
);

// File: tb/i2c_strap_target_tb.sv
module i2c_strap_target_tb;

   localparam int Q = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   int         mode_a1 = 1;
   int         mode_a0 = 3;
   logic       scl_bus, sda_bus;
   logic [1:0] straps;
   logic       sda_pull, addr_match, rw;
   logic [6:0] addr;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 0;

   always #10 clk = ~clk;

   function automatic logic strap_val(int mode, logic scl, logic sda);
      case (mode)
         0:       return 1'b0;
         1:       return 1'b1;
         2:       return sda;
         3:       return scl;
         default: return ~sda;
      endcase
   endfunction

   assign scl_bus   = m_scl;
   assign sda_bus   = m_sda & ~sda_pull;
   assign straps[1] = strap_val(mode_a1, scl_bus, sda_bus);
   assign straps[0] = strap_val(mode_a0, scl_bus, sda_bus);

   i2c_strap_target u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_bus),
      .sda_i       (sda_bus),
      .straps_i    (straps),
      .sda_pull_o  (sda_pull),
      .addr_match_o(addr_match),
      .rw_o        (rw),
      .addr_o      (addr)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [6:0] exp_addr();
      if (mode_a1 > 3 || mode_a0 > 3) return 7'h00;
      return {3'b100, 2'(mode_a1), 2'(mode_a0)};
   endfunction

   // reference model: bus view delayed by synchroniser depth plus one
   logic [1:0] hist[$];
   int         mst = 0;
   int         mcnt = 0;
   logic [7:0] msh = '0;
   logic       e_pull = 0, e_match = 0, e_rw = 0;
   logic [6:0] e_addr = '0;

   initial for (int i = 0; i < 8; i++) hist.push_back(2'b11);

   always @(negedge clk) begin
      logic [1:0] s, p;
      bit st, sp, rs, fl;
      hist.push_back({scl_bus, sda_bus});
      if (hist.size() > 8) void'(hist.pop_front());
      if (!rst_n) begin
         mst = 0; e_pull = 0; e_match = 0; e_rw = 0; e_addr = '0;
         check("R10 reset pull", int'(sda_pull), 0);
         check("R10 reset match", int'(addr_match), 0);
         check("R10 reset rw", int'(rw), 0);
         check("R10 reset addr", int'(addr), 0);
      end else begin
         s  = hist[hist.size()-4];
         p  = hist[hist.size()-5];
         st = s[1] && p[1] && p[0] && !s[0];
         sp = s[1] && p[1] && !p[0] && s[0];
         rs = s[1] && !p[1];
         fl = !s[1] && p[1];
         if (st) begin
            mst = 1; mcnt = 0; e_pull = 0; e_match = 0;
         end else if (sp) begin
            mst = 0; e_pull = 0; e_match = 0;
         end else begin
            case (mst)
               1: if (rs) begin
                     msh = {msh[6:0], s[0]};
                     mcnt++;
                     if (mcnt == 8) begin
                        e_rw   = s[0];
                        e_addr = exp_addr();
                        if (e_addr != 0 && msh[7:1] == e_addr) begin
                           e_match = 1; mst = 2;
                        end else mst = 5;
                     end
                  end
               2: if (fl) begin e_pull = 1; mst = 3; end
               3: if (fl) begin e_pull = 0; mst = 4; end
               default: ;
            endcase
         end
         check(mst == 5 ? "R6 pull" : "R5 pull", int'(sda_pull), int'(e_pull));
         check("R4 match", int'(addr_match), int'(e_match));
         check("R2 rw", int'(rw), int'(e_rw));
         check((mode_a1 > 3 || mode_a0 > 3) ? "R9 addr" : "R3 addr", int'(addr), int'(e_addr));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(2*Q);
      m_scl = 1'b0;
   endtask

   task automatic do_stop();
      tick(1);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(2*Q);
   endtask

   task automatic send_bit(input logic b);
      tick(Q);
      m_sda = b; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
   endtask

   initial begin
      tick(10);
      rst_n = 1'b1;
      tick(10);

      // matched write, straps VS / SCL -> 1000111
      mode_a1 = 1; mode_a0 = 3;
      do_start();
      send_byte({7'b1000111, 1'b0});
      check("R4 match after address", int'(addr_match), 1);
      send_bit(1'b1);
      send_byte(8'h5A);
      send_bit(1'b1);
      do_stop();
      check("R1 match cleared by stop", int'(addr_match), 0);

      // mismatch, straps SDA / SDA -> 1001010, then a further byte
      mode_a1 = 2; mode_a0 = 2;
      do_start();
      send_byte({7'b1000000, 1'b1});
      send_bit(1'b1);
      send_byte(8'h00);
      check("R6 no pull after mismatch", int'(sda_pull), 0);
      send_bit(1'b1);
      do_stop();
      check("R3 sda straps resolved", int'(addr), 7'b1001010);

      // unclassifiable strap (inverted data)
      mode_a1 = 4; mode_a0 = 0;
      do_start();
      send_byte({7'b1000000, 1'b0});
      check("R9 addr reports zero", int'(addr), 0);
      check("R9 no match", int'(addr_match), 0);
      send_bit(1'b1);
      do_stop();

      // repeated start turns a mismatch into a match
      mode_a1 = 0; mode_a0 = 1;
      do_start();
      send_byte({7'b1001111, 1'b0});
      send_bit(1'b1);
      check("R8 first pass mismatched", int'(addr_match), 0);
      do_start();
      send_byte({7'b1000001, 1'b1});
      check("R8 match after repeated start", int'(addr_match), 1);
      check("R2 read bit", int'(rw), 1);
      send_bit(1'b1);
      do_stop();

      // every strap pairing, re-resolved per transfer
      for (int a1 = 0; a1 < 4; a1++) begin
         for (int a0 = 0; a0 < 4; a0++) begin
            mode_a1 = a1; mode_a0 = a0;
            do_start();
            send_byte({3'b100, 2'(a1), 2'(a0), 1'((a1 + a0) % 2)});
            check("R7 re-resolved address", int'(addr), int'({3'b100, 2'(a1), 2'(a0)}));
            check("R7 match", int'(addr_match), 1);
            send_bit(1'b1);
            do_stop();
         end
      end

      tick(10);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule